// File: doc/BRIEF.md
# Link Error Logging Controller

This block gathers error events from the receivers of two point-to-point serial links and records them in sticky status bits that software reads and clears. Each link reports CRC errors separately for each of its two byte lanes, and reports protocol errors. A separate strobe marks the protocol error raised when the control line drops inside a CRC window. Each link also presents the level of its control input. Detected errors are not recorded at once. They wait until that link's control input is next seen high, and a link reset that comes first throws them away. The one exception is a control-line watchdog timeout, which is recorded immediately.

Recorded errors drive three kinds of action, each under its own enable bit. Sync-flood requests go to every active transmitter. Level-sensitive fatal and nonfatal interrupts stay up until software clears the causing bits. A protocol error also locks that link's receiver when protocol flooding is enabled. A sync flood seen on an initialized receiver is relayed to the active transmitters without any enable and without logging. Two synchronous active-high resets are provided. The cold reset clears everything. The link reset clears pending errors, the watchdog, locks and flood requests, and leaves the logged bits and the control register untouched.

Top module: `link_err_log`

## Requirements
- R1: After cold reset, the status register (address 0) and the control register (address 1) read 0, and all flood, lock and interrupt outputs are 0.
- R2: Status bits are sticky. A link reset leaves them unchanged. Writing 1 to a bit at address 0 clears it, and writing 0 has no effect. If an error is recorded on the same edge as a clear of its bit, the bit stays set. Status layout: bit 3L+N is the CRC error of link L, lane N; bit 3L+2 is the protocol error of link L.
- R3: A CRC error strobe makes the error pending. Its status bit is set on the first clock edge at which the error is pending and that link's control input is high. A link reset before that edge discards the error.
- R4: Protocol error strobes, including the control-drop-in-CRC kind, are deferred and discarded in the same way as R3.
- R5: While a link is initialized and its control input is low, a watchdog counts core cycles. It restarts whenever the control input is high. When the control input has been low at TO_SHORT consecutive edges (TO_LONG when control bit 7 is 1), the link's protocol bit is set on that edge. The watchdog fires only once per low period.
- R6: Control bit L (L = 0, 1) lets any set CRC bit of link L raise flood requests. These requests go on the next edge to every transmitter whose active input is high.
- R7: With control bit 2 set, any set protocol bit raises flood requests to the active transmitters. In the same case, a protocol error strobe or a watchdog expiry locks that link's receiver on the next edge. The control-drop-in-CRC strobe never locks the receiver.
- R8: A sync flood detected on a receiver whose initialized input is high raises flood requests to all active transmitters on the next edge. It needs no enable and sets no status bit. A receiver that is not initialized does not raise these requests.
- R9: irq_fatal_o is high while any CRC bit is set with control bit 3, or any protocol bit is set with control bit 5. irq_nonfatal_o is the same with control bits 4 and 6.
- R10: Receiver locks and flood requests, once raised, stay high until a link reset, even after the status bits or enables are cleared.
- R11: Address 1 reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_cold_i | input | 1 | Cold reset, synchronous, clears all state |
| rst_link_i | input | 1 | Link (warm) reset, synchronous, keeps logs and control |
| ctl_i | input | 2 | Control input level per link |
| crc_err_i | input | 4 | CRC error strobes, bit 2L+N = link L, lane N |
| proto_err_i | input | 2 | Protocol error strobe per link |
| proto_exempt_i | input | 2 | Control-drop-in-CRC protocol error strobe per link |
| rx_init_i | input | 2 | Receiver initialized per link |
| flood_det_i | input | 2 | Sync flood detected on receiver per link |
| tx_active_i | input | 2 | Transmitter active per link |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 status, 1 control) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| flood_o | output | 2 | Sync-flood request per transmitter |
| irq_fatal_o | output | 1 | Fatal interrupt level |
| irq_nonfatal_o | output | 1 | Nonfatal interrupt level |
| rx_lock_o | output | 2 | Receiver lock per link |

## Verification
Several rules are checked by assertions on every cycle. Logged bits hold unless a clear arrives. No bit can rise while its control input is low, except through a timeout. A link reset empties the pending state. Locks and flood requests hold until link reset. The watchdog never fires on two consecutive edges. The exempt strobe never locks a receiver. The control register changes only when it is written. Other behaviour can only be shown by the directed scenarios in the bench: the exact edge on which a timeout expires for each length, the lane-and-link bit mapping, the set-over-clear priority, the interrupt enables, and the gating of relayed floods by the initialized and active inputs.

// File: rtl/lel_pkg.sv
package lel_pkg;

    localparam int NUM_LINKS     = 2;
    localparam int NUM_LANES     = 2;
    localparam int STAT_PER_LINK = NUM_LANES + 1;
    localparam int STAT_W        = NUM_LINKS * STAT_PER_LINK;
    localparam int REG_AW        = 2;
    localparam int REG_DW        = 8;
    localparam int ADDR_STATUS   = 0;
    localparam int ADDR_CTRL     = 1;

    // Control register, bit 0 is crc_flood[0], bit 7 is tmr_long.
    typedef struct packed {
        logic                 tmr_long;
        logic                 prt_nfat;
        logic                 prt_fat;
        logic                 crc_nfat;
        logic                 crc_fat;
        logic                 prt_flood;
        logic [NUM_LINKS-1:0] crc_flood;
    } lel_ctrl_t;

    function automatic int crc_bit(int link, int lane);
        return link * STAT_PER_LINK + lane;
    endfunction

    function automatic int proto_bit(int link);
        return link * STAT_PER_LINK + NUM_LANES;
    endfunction

endpackage

// File: rtl/lel_ctl_timer.sv
module lel_ctl_timer #(
    parameter int TO_SHORT = 16,
    parameter int TO_LONG  = 64
) (
    input  logic clk,
    input  logic rst_cold,
    input  logic rst_link,
    input  logic rx_init_i,
    input  logic ctl_i,
    input  logic long_sel_i,
    output logic expire_o
);
    localparam int CW = $clog2(TO_LONG + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          run;

    assign limit    = long_sel_i ? CW'(TO_LONG) : CW'(TO_SHORT);
    assign run      = rx_init_i & ~ctl_i;
    assign expire_o = run & (cnt_q == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst_cold || rst_link || !run) begin
            cnt_q <= '0;
        end else if (cnt_q < limit) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R5: one expiry per low period, never on back-to-back edges
    p_single_fire_r5: assert property (@(posedge clk) disable iff (rst_cold)
        expire_o |=> !expire_o);

endmodule

// File: rtl/lel_link_log.sv
module lel_link_log #(
    parameter int NLANE = 2
) (
    input  logic             clk,
    input  logic             rst_cold,
    input  logic             rst_link,
    input  logic             ctl_i,
    input  logic [NLANE-1:0] crc_err_i,
    input  logic             proto_err_i,
    input  logic             proto_exempt_i,
    input  logic             tmo_i,
    input  logic             lock_en_i,
    input  logic [NLANE-1:0] clr_crc_i,
    input  logic             clr_proto_i,
    output logic [NLANE-1:0] crc_log_o,
    output logic             proto_log_o,
    output logic             lock_o
);
    logic [NLANE-1:0] crc_pend_q;
    logic [NLANE-1:0] crc_log_q;
    logic             proto_pend_q;
    logic             proto_log_q;
    logic             lock_q;
    logic             commit;

    // pending errors move into the log only while control is high
    assign commit = ctl_i & ~rst_link;

    always_ff @(posedge clk) begin
        if (rst_cold) begin
            crc_pend_q   <= '0;
            crc_log_q    <= '0;
            proto_pend_q <= 1'b0;
            proto_log_q  <= 1'b0;
            lock_q       <= 1'b0;
        end else begin
            crc_pend_q   <= rst_link ? '0
                          : ((crc_pend_q & {NLANE{~ctl_i}}) | crc_err_i);
            crc_log_q    <= (crc_log_q & ~clr_crc_i) | (crc_pend_q & {NLANE{commit}});
            proto_pend_q <= rst_link ? 1'b0
                          : ((proto_pend_q & ~ctl_i) | proto_err_i | proto_exempt_i);
            proto_log_q  <= (proto_log_q & ~clr_proto_i) | (proto_pend_q & commit) | tmo_i;
            lock_q       <= rst_link ? 1'b0
                          : (lock_q | (lock_en_i & (proto_err_i | tmo_i)));
        end
    end

    assign crc_log_o   = crc_log_q;
    assign proto_log_o = proto_log_q;
    assign lock_o      = lock_q;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane_chk
        // R2: a logged bit holds unless cleared
        p_crc_sticky_r2: assert property (@(posedge clk) disable iff (rst_cold)
            (crc_log_q[g] && !clr_crc_i[g]) |=> crc_log_q[g]);
        // R3: a CRC bit cannot rise while control is low
        p_crc_defer_r3: assert property (@(posedge clk) disable iff (rst_cold)
            (!crc_log_q[g] && !ctl_i) |=> !crc_log_q[g]);
    end

    p_proto_sticky_r2: assert property (@(posedge clk) disable iff (rst_cold)
        (proto_log_q && !clr_proto_i) |=> proto_log_q);

    // R4: protocol bit rises with control low only through a timeout
    p_proto_defer_r4: assert property (@(posedge clk) disable iff (rst_cold)
        (!proto_log_q && !ctl_i && !tmo_i) |=> !proto_log_q);

    // R3/R4: link reset empties the pending state
    p_drop_pend_r3: assert property (@(posedge clk) disable iff (rst_cold)
        rst_link |=> (crc_pend_q == '0) && !proto_pend_q);

    // R7: the exempt kind never locks the receiver
    p_exempt_nolock_r7: assert property (@(posedge clk) disable iff (rst_cold)
        (proto_exempt_i && !proto_err_i && !tmo_i && !lock_q) |=> !lock_q);

endmodule

// File: rtl/lel_regs.sv
module lel_regs
    import lel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_cold,
    input  logic                 wr_en_i,
    input  logic [REG_AW-1:0]    addr_i,
    input  logic [REG_DW-1:0]    wdata_i,
    input  logic [STAT_W-1:0]    status_i,
    output lel_ctrl_t            ctrl_o,
    output logic [STAT_W-1:0]    clr_o,
    output logic [REG_DW-1:0]    rdata_o
);
    lel_ctrl_t ctrl_q;
    logic      hit_status;
    logic      hit_ctrl;

    assign hit_status = (addr_i == REG_AW'(ADDR_STATUS));
    assign hit_ctrl   = (addr_i == REG_AW'(ADDR_CTRL));

    always_ff @(posedge clk) begin
        if (rst_cold) begin
            ctrl_q <= '0;
        end else if (wr_en_i && hit_ctrl) begin
            ctrl_q <= lel_ctrl_t'(wdata_i);
        end
    end

    assign clr_o  = (wr_en_i && hit_status) ? wdata_i[STAT_W-1:0] : '0;
    assign ctrl_o = ctrl_q;

    always_comb begin
        rdata_o = '0;
        if (hit_status) begin
            rdata_o = REG_DW'(status_i);
        end else if (hit_ctrl) begin
            rdata_o = ctrl_q;
        end
    end

    // R11: control changes only on a write to its address
    p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (rst_cold)
        !(wr_en_i && hit_ctrl) |=> $stable(ctrl_q));

endmodule

// File: rtl/link_err_log.sv
module link_err_log
    import lel_pkg::*;
#(
    parameter int TO_SHORT = 16,
    parameter int TO_LONG  = 64
) (
    input  logic                           clk,
    input  logic                           rst_cold_i,
    input  logic                           rst_link_i,
    input  logic [NUM_LINKS-1:0]           ctl_i,
    input  logic [NUM_LINKS*NUM_LANES-1:0] crc_err_i,
    input  logic [NUM_LINKS-1:0]           proto_err_i,
    input  logic [NUM_LINKS-1:0]           proto_exempt_i,
    input  logic [NUM_LINKS-1:0]           rx_init_i,
    input  logic [NUM_LINKS-1:0]           flood_det_i,
    input  logic [NUM_LINKS-1:0]           tx_active_i,
    input  logic                           reg_wr_i,
    input  logic [REG_AW-1:0]              reg_addr_i,
    input  logic [REG_DW-1:0]              reg_wdata_i,
    output logic [REG_DW-1:0]              reg_rdata_o,
    output logic [NUM_LINKS-1:0]           flood_o,
    output logic                           irq_fatal_o,
    output logic                           irq_nonfatal_o,
    output logic [NUM_LINKS-1:0]           rx_lock_o
);
    lel_ctrl_t                            ctrl;
    logic [STAT_W-1:0]                    status;
    logic [STAT_W-1:0]                    clr;
    logic [NUM_LINKS-1:0][NUM_LANES-1:0]  crc_log;
    logic [NUM_LINKS-1:0]                 proto_log;
    logic [NUM_LINKS-1:0]                 tmo;
    logic [NUM_LINKS-1:0]                 lock;
    logic [NUM_LINKS-1:0]                 crc_hit;
    logic [NUM_LINKS-1:0]                 flood_q;
    logic                                 relay;
    logic                                 trig;

    lel_regs u_regs (
        .clk      (clk),
        .rst_cold (rst_cold_i),
        .wr_en_i  (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .status_i (status),
        .ctrl_o   (ctrl),
        .clr_o    (clr),
        .rdata_o  (reg_rdata_o)
    );

    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
        lel_ctl_timer #(
            .TO_SHORT (TO_SHORT),
            .TO_LONG  (TO_LONG)
        ) u_timer (
            .clk        (clk),
            .rst_cold   (rst_cold_i),
            .rst_link   (rst_link_i),
            .rx_init_i  (rx_init_i[l]),
            .ctl_i      (ctl_i[l]),
            .long_sel_i (ctrl.tmr_long),
            .expire_o   (tmo[l])
        );

        lel_link_log #(
            .NLANE (NUM_LANES)
        ) u_log (
            .clk            (clk),
            .rst_cold       (rst_cold_i),
            .rst_link       (rst_link_i),
            .ctl_i          (ctl_i[l]),
            .crc_err_i      (crc_err_i[l*NUM_LANES +: NUM_LANES]),
            .proto_err_i    (proto_err_i[l]),
            .proto_exempt_i (proto_exempt_i[l]),
            .tmo_i          (tmo[l]),
            .lock_en_i      (ctrl.prt_flood),
            .clr_crc_i      (clr[crc_bit(l, 0) +: NUM_LANES]),
            .clr_proto_i    (clr[proto_bit(l)]),
            .crc_log_o      (crc_log[l]),
            .proto_log_o    (proto_log[l]),
            .lock_o         (lock[l])
        );

        assign crc_hit[l] = (|crc_log[l]) & ctrl.crc_flood[l];

        // R10: lock and flood hold until link reset
        p_lock_hold_r10: assert property (@(posedge clk) disable iff (rst_cold_i)
            (rx_lock_o[l] && !rst_link_i) |=> rx_lock_o[l]);
        p_flood_hold_r10: assert property (@(posedge clk) disable iff (rst_cold_i)
            (flood_o[l] && !rst_link_i) |=> flood_o[l]);
        // R8: relayed flood reaches every active transmitter
        p_relay_r8: assert property (@(posedge clk) disable iff (rst_cold_i)
            ((|(rx_init_i & flood_det_i)) && tx_active_i[l] && !rst_link_i) |=> flood_o[l]);
    end

    always_comb begin
        status = '0;
        for (int l = 0; l < NUM_LINKS; l++) begin
            status[crc_bit(l, 0) +: NUM_LANES] = crc_log[l];
            status[proto_bit(l)]               = proto_log[l];
        end
    end

    assign relay = |(rx_init_i & flood_det_i);
    assign trig  = (|crc_hit) | ((|proto_log) & ctrl.prt_flood) | relay;

    always_ff @(posedge clk) begin
        if (rst_cold_i || rst_link_i) begin
            flood_q <= '0;
        end else begin
            flood_q <= flood_q | ({NUM_LINKS{trig}} & tx_active_i);
        end
    end

    assign flood_o        = flood_q;
    assign rx_lock_o      = lock;
    assign irq_fatal_o    = ((|crc_log) & ctrl.crc_fat)  | ((|proto_log) & ctrl.prt_fat);
    assign irq_nonfatal_o = ((|crc_log) & ctrl.crc_nfat) | ((|proto_log) & ctrl.prt_nfat);

endmodule

// File: tb/link_err_log_tb.sv
module link_err_log_tb;
    localparam int TS = 16;
    localparam int TL = 64;

    logic       clk = 1'b0;
    logic       rst_cold, rst_link, reg_wr;
    logic [1:0] ctl, proto_err, proto_exempt, rx_init, flood_det, tx_active;
    logic [3:0] crc_err;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [1:0] flood, rx_lock;
    logic       irq_fat, irq_nfat;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    link_err_log #(.TO_SHORT(TS), .TO_LONG(TL)) u_dut (
        .clk(clk), .rst_cold_i(rst_cold), .rst_link_i(rst_link), .ctl_i(ctl),
        .crc_err_i(crc_err), .proto_err_i(proto_err), .proto_exempt_i(proto_exempt),
        .rx_init_i(rx_init), .flood_det_i(flood_det), .tx_active_i(tx_active),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .flood_o(flood), .irq_fatal_o(irq_fat),
        .irq_nonfatal_o(irq_nfat), .rx_lock_o(rx_lock)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic link_reset();
        rst_link = 1'b1; tick(1); rst_link = 1'b0;
    endtask

    task automatic crc_pulse(int idx);
        crc_err[idx] = 1'b1; tick(1); crc_err = '0;
    endtask

    task automatic proto_pulse(int link);
        proto_err[link] = 1'b1; tick(1); proto_err = '0;
    endtask

    task automatic exempt_pulse(int link);
        proto_exempt[link] = 1'b1; tick(1); proto_exempt = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        reg_read(0, d); chk("R1 status after cold reset", d, 0);
        reg_read(1, d); chk("R1 control after cold reset", d, 0);
        chk("R1 outputs after cold reset", {flood, rx_lock, irq_fat, irq_nfat}, 0);
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        reg_write(1, 8'h5A);
        reg_read(1, d); chk("R11 control readback", d, 8'h5A);
        reg_read(0, d); chk("R11 status untouched by control write", d, 0);
        reg_write(1, 8'h00);
    endtask

    task automatic t_crc_defer();
        logic [7:0] d;
        ctl = 2'b00;
        crc_pulse(2);
        tick(3);
        reg_read(0, d); chk("R3 CRC held while control low", d, 0);
        ctl[1] = 1'b1; tick(1);
        reg_read(0, d); chk("R3 CRC link1 lane0 logged", d, 8'h08);
        crc_pulse(1);
        ctl[0] = 1'b1; tick(1);
        reg_read(0, d); chk("R3 CRC link0 lane1 logged", d, 8'h0A);
    endtask

    task automatic t_crc_drop();
        logic [7:0] d;
        ctl = 2'b00;
        crc_pulse(0);
        link_reset();
        ctl = 2'b11; tick(2);
        reg_read(0, d); chk("R3 pending dropped by link reset", d, 8'h0A);
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        link_reset();
        reg_read(0, d); chk("R2 logs survive link reset", d, 8'h0A);
        reg_write(0, 8'h02);
        reg_read(0, d); chk("R2 write-one clears one bit", d, 8'h08);
        reg_write(0, 8'h00);
        reg_read(0, d); chk("R2 write-zero no effect", d, 8'h08);
        reg_write(0, 8'h08);
        reg_read(0, d); chk("R2 cleared", d, 0);
        ctl = 2'b11;
        crc_err[0] = 1'b1; tick(1); crc_err = '0;
        reg_write(0, 8'h01);
        reg_read(0, d); chk("R2 set wins over clear", d, 8'h01);
        reg_write(0, 8'h01);
    endtask

    task automatic t_proto_defer();
        logic [7:0] d;
        ctl = 2'b00;
        proto_pulse(0);
        tick(2);
        reg_read(0, d); chk("R4 protocol held while control low", d, 0);
        ctl[0] = 1'b1; tick(1);
        reg_read(0, d); chk("R4 protocol link0 logged", d, 8'h04);
        exempt_pulse(1);
        ctl[1] = 1'b1; tick(1);
        reg_read(0, d); chk("R4 exempt kind logged deferred", d, 8'h24);
        chk("R7 no lock with flood disabled", rx_lock, 0);
        reg_write(0, 8'h24);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        ctl = 2'b11; tx_active = 2'b00;
        reg_write(1, 8'h04);
        proto_pulse(1);
        chk("R7 protocol error locks link1", rx_lock, 2'b10);
        exempt_pulse(0);
        tick(1);
        chk("R7 exempt error does not lock", rx_lock, 2'b10);
        chk("R6 no flood without active transmitter", flood, 0);
        reg_read(0, d); chk("R4 both protocol bits logged", d, 8'h24);
        tx_active = 2'b11; tick(1);
        chk("R7 protocol flood to active transmitters", flood, 2'b11);
        reg_write(0, 8'h24);
        reg_write(1, 8'h00);
        tick(2);
        chk("R10 flood held after cause cleared", flood, 2'b11);
        chk("R10 lock held after cause cleared", rx_lock, 2'b10);
        link_reset();
        chk("R10 link reset releases flood and lock", {flood, rx_lock}, 0);
    endtask

    task automatic t_crc_flood();
        logic [7:0] d;
        tx_active = 2'b11;
        reg_write(1, 8'h01);
        crc_pulse(3); tick(3);
        chk("R6 link1 CRC without its enable", flood, 0);
        crc_pulse(0); tick(2);
        chk("R6 link0 CRC with enable floods", flood, 2'b11);
        reg_read(0, d); chk("R2 lane bit map", d, 8'h11);
        reg_write(0, 8'h11);
        reg_write(1, 8'h00);
        link_reset();
        chk("R10 flood cleared by link reset", flood, 0);
    endtask

    task automatic t_relay();
        logic [7:0] d;
        tx_active = 2'b01; flood_det = 2'b11; rx_init = 2'b00;
        tick(3);
        chk("R8 uninitialized receiver not relayed", flood, 0);
        rx_init[1] = 1'b1; tick(1);
        chk("R8 relay to active transmitter only", flood, 2'b01);
        reg_read(0, d); chk("R8 relay not logged", d, 0);
        flood_det = '0; rx_init = '0; tx_active = '0;
        link_reset();
    endtask

    task automatic t_irq();
        reg_write(1, 8'h08);
        crc_pulse(1); tick(1);
        chk("R9 CRC fatal interrupt", {irq_fat, irq_nfat}, 2'b10);
        reg_write(1, 8'h48);
        chk("R9 nonfatal needs protocol bit", irq_nfat, 0);
        proto_pulse(0); tick(1);
        chk("R9 protocol nonfatal interrupt", {irq_fat, irq_nfat}, 2'b11);
        reg_write(0, 8'h02);
        chk("R9 fatal drops on clear", {irq_fat, irq_nfat}, 2'b01);
        reg_write(0, 8'h04);
        chk("R9 nonfatal drops on clear", {irq_fat, irq_nfat}, 2'b00);
        reg_write(1, 8'h00);
    endtask

    task automatic t_timeout();
        logic [7:0] d;
        ctl[0] = 1'b0; rx_init[0] = 1'b1;
        tick(TS - 1);
        reg_read(0, d); chk("R5 short timer one edge early", d, 0);
        tick(1);
        reg_read(0, d); chk("R5 short timer expiry logs at once", d, 8'h04);
        chk("R7 timeout without flood enable no lock", rx_lock, 0);
        reg_write(0, 8'h04);
        tick(5);
        reg_read(0, d); chk("R5 single expiry per low period", d, 0);
        ctl[0] = 1'b1; tick(1);
        ctl[0] = 1'b0; tick(TS - 2);
        ctl[0] = 1'b1; tick(1);
        ctl[0] = 1'b0; tick(TS - 1);
        reg_read(0, d); chk("R5 control high restarts timer", d, 0);
        tick(1);
        reg_read(0, d); chk("R5 expiry after restart", d, 8'h04);
        reg_write(0, 8'h04);
        reg_write(1, 8'h84);
        ctl[0] = 1'b1; tick(1);
        ctl[0] = 1'b0;
        tick(TL - 1);
        reg_read(0, d); chk("R5 long timer one edge early", d, 0);
        chk("R7 no lock before long expiry", rx_lock, 0);
        tick(1);
        reg_read(0, d); chk("R5 long timer expiry", d, 8'h04);
        chk("R7 timeout locks with flood enable", rx_lock, 2'b01);
        rx_init = '0; ctl = 2'b11;
        reg_write(0, 8'h04);
        reg_write(1, 8'h00);
        link_reset();
    endtask

    task automatic t_cold();
        logic [7:0] d;
        reg_write(1, 8'hFF);
        crc_pulse(0); tick(1);
        chk("R9 fatal before cold reset", irq_fat, 1);
        rst_cold = 1'b1; tick(2); rst_cold = 1'b0;
        reg_read(0, d); chk("R1 cold reset clears logs", d, 0);
        reg_read(1, d); chk("R1 cold reset clears control", d, 0);
        chk("R1 cold reset clears outputs", {flood, rx_lock, irq_fat, irq_nfat}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_cold = 1'b1; rst_link = 1'b0; reg_wr = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        ctl = 2'b11; crc_err = '0; proto_err = '0; proto_exempt = '0;
        rx_init = '0; flood_det = '0; tx_active = '0;
        tick(3);
        rst_cold = 1'b0;
        tick(1);
        t_reset();
        t_ctrl();
        t_crc_defer();
        t_crc_drop();
        t_sticky();
        t_proto_defer();
        t_lock();
        t_crc_flood();
        t_relay();
        t_irq();
        t_timeout();
        t_cold();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule